// File: doc/BRIEF.md
# Bit-Time Timestamp Counter

This block keeps a 16-bit running count of bus bit times for a CAN controller. The count advances once for each `bit_tick` pulse from the bit-timing unit, which pulses for every bit on the bus during a frame and at the programmed baud rate when the bus is idle. It wraps from 0xFFFF to 0x0000 and stops while `freeze` is high. When the protocol engine marks the start of a frame's identifier field, the block latches the count. When the engine then reports that the frame completed, the block hands the latched value to the message-buffer logic with a one-cycle valid strobe. A frame that ends in error yields no strobe.

The CPU runs on its own clock. A CPU write lands in a holding register and sets a pending flag. A toggle request crosses to the CAN clock through a two-flop synchronizer, loads the counter, and returns as a toggle acknowledge through a second two-flop synchronizer. That acknowledge clears the pending flag. A second toggle loop copies the count into the CPU domain so that software can read it.

Finite-state machines: the frame capture FSM has states FR_IDLE and FR_HELD. Its transitions are arm (FR_IDLE to FR_HELD on `id_start`), commit (FR_HELD to FR_IDLE on `frame_ok`), abort (FR_HELD to FR_IDLE on `frame_err`) and recapture (FR_HELD to FR_HELD on `id_start`). The write bridge FSM has states WR_IDLE and WR_WAIT. Its transitions are accept (WR_IDLE to WR_WAIT on `cpu_wr_en`) and retire (WR_WAIT to WR_IDLE when the synchronized acknowledge equals the request toggle).

Top module: `cts_timer`

## Requirements
- R1: After reset, `count_out` is 0x0000, `cpu_wr_pending` is 0 and `ts_valid` is 0.
- R2: At each `can_clk` edge where `bit_tick` is 1 and `freeze` is 0, the count increases by one. With `bit_tick` at 0 the count holds.
- R3: A counted tick at 0xFFFF gives 0x0000.
- R4: While `freeze` is 1, ticks are not counted and the count holds.
- R5: `id_start` latches the value that `count_out` shows in that same cycle. A second `id_start` before the frame ends replaces the latched value.
- R6: `frame_ok` in a cycle after an `id_start` drives `ts_valid` high for exactly one cycle on the next edge, with `ts_value` equal to the latched value. `frame_ok` with no open frame gives no strobe.
- R7: `frame_err` discards the open frame. It gives no strobe, and a later `frame_ok` without a new `id_start` also gives no strobe. When both arrive together, the error wins.
- R8: A CPU write accepted at a `cpu_clk` edge is loaded into the counter after the request passes a two-flop synchronizer in the CAN domain and one load cycle. With the bench's clock phasing, that is the third `can_clk` edge after acceptance.
- R9: `cpu_wr_pending` rises after the accepting edge. It falls after the acknowledge passes a two-flop synchronizer in the CPU domain, which is five `cpu_clk` edges after acceptance with the bench's phasing. Writes while pending are ignored.
- R10: In the load cycle a tick is not counted, and the counter takes exactly the written value.
- R11: A CPU write takes effect even while `freeze` is 1.
- R12: `cpu_rd_data` follows the count. When the count stays constant, `cpu_rd_data` equals it within a bounded number of CPU cycles.
- R13: The holding register stays unchanged from request until acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| can_clk | input | 1 | CAN-domain clock |
| can_rst_n | input | 1 | CAN-domain reset, active low, asynchronous |
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst_n | input | 1 | CPU-domain reset, active low, asynchronous |
| bit_tick | input | 1 | One pulse per bus bit time |
| freeze | input | 1 | Stops counting while high |
| id_start | input | 1 | Start of identifier field |
| frame_ok | input | 1 | Frame sent or received successfully |
| frame_err | input | 1 | Frame aborted or in error |
| cpu_wr_en | input | 1 | CPU write strobe (cpu_clk) |
| cpu_wr_data | input | 16 | CPU write value |
| cpu_rd_data | output | 16 | Count as seen in the CPU domain |
| cpu_wr_pending | output | 1 | A write has not yet reached the counter |
| count_out | output | 16 | Current count (can_clk) |
| ts_valid | output | 1 | One-cycle timestamp strobe |
| ts_value | output | 16 | Committed timestamp |

## Verification
The bench drives the counter across 0xFFFF with a load followed by ticks. A design that saturated there or skipped zero would diverge from the reference on the next compare. It holds `bit_tick` high through CPU write transfers. A design that counted the tick in the load cycle, or loaded one edge early or late, would show the written value off by one or in the wrong cycle. It also issues a write while an earlier one is pending, and a design that let the second write through would load the wrong value. Error-terminated frames are followed by `frame_ok` with no new `id_start`, and an error that arrives together with `frame_ok` must still suppress the strobe. Each of these cases would otherwise produce a stray timestamp.

// File: rtl/cts_pkg.sv
package cts_pkg;
    localparam int CTS_W = 16;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {FR_IDLE, FR_HELD} fr_state_t;
    typedef enum logic {WR_IDLE, WR_WAIT} wr_state_t;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int W = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cts_wr_bridge.sv
module cts_wr_bridge
    import cts_pkg::*;
#(
    parameter int W = CTS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic         cpu_wr_en,
    input  logic [W-1:0] cpu_wr_data,
    output logic         cpu_pending,
    input  logic         can_clk,
    input  logic         can_rst_n,
    output logic         load_en,
    output logic [W-1:0] load_val
);
    wr_state_t    state, state_nx;
    logic         req_tgl;
    logic [W-1:0] hold;
    logic         ack_s;
    logic         req_s;
    logic         seen;
    logic         accept;

    // CPU domain: state register
    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) state <= WR_IDLE;
        else            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            WR_IDLE: if (cpu_wr_en) begin
                state_nx = WR_WAIT;
                accept   = 1'b1;
            end
            WR_WAIT: if (ack_s == req_tgl) state_nx = WR_IDLE;
        endcase
    end

    // CPU domain: outputs
    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) begin
            req_tgl <= 1'b0;
            hold    <= '0;
        end else if (accept) begin
            req_tgl <= ~req_tgl;
            hold    <= cpu_wr_data;
        end
    end

    assign cpu_pending = (state == WR_WAIT);

    cts_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(can_clk), .rst_n(can_rst_n), .d(req_tgl), .q(req_s)
    );

    // CAN domain: detect the request toggle and acknowledge it
    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) seen <= 1'b0;
        else            seen <= req_s;
    end

    assign load_en  = req_s ^ seen;
    assign load_val = hold;

    cts_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(seen), .q(ack_s)
    );

    // R13
    hold_stable_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        cpu_pending |=> $stable(hold));

    // R9
    wr_ignore_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        (cpu_pending && cpu_wr_en) |=> $stable(req_tgl));
endmodule

// File: rtl/cts_rd_mirror.sv
module cts_rd_mirror
    import cts_pkg::*;
#(
    parameter int W = CTS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         can_clk,
    input  logic         can_rst_n,
    input  logic [W-1:0] count,
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] mirror;
    logic         pub_tgl;
    logic         take_s;
    logic         pub_s;
    logic         take;

    // CAN domain: publish a new snapshot once the last one was taken
    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) begin
            mirror  <= '0;
            pub_tgl <= 1'b0;
        end else if (take_s == pub_tgl) begin
            mirror  <= count;
            pub_tgl <= ~pub_tgl;
        end
    end

    cts_sync #(.W(1), .STAGES(STAGES)) u_pub_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .d(pub_tgl), .q(pub_s)
    );

    // CPU domain: take the snapshot when the toggle arrives
    always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) begin
            rd_data <= '0;
            take    <= 1'b0;
        end else if (pub_s != take) begin
            rd_data <= mirror;
            take    <= pub_s;
        end
    end

    cts_sync #(.W(1), .STAGES(STAGES)) u_take_sync (
        .clk(can_clk), .rst_n(can_rst_n), .d(take), .q(take_s)
    );

    // R12
    mirror_stable_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        (take_s != pub_tgl) |=> $stable(mirror));
endmodule

// File: rtl/cts_frame_ts.sv
module cts_frame_ts
    import cts_pkg::*;
#(
    parameter int W = CTS_W
) (
    input  logic         can_clk,
    input  logic         can_rst_n,
    input  logic [W-1:0] count,
    input  logic         id_start,
    input  logic         frame_ok,
    input  logic         frame_err,
    output logic         ts_valid,
    output logic [W-1:0] ts_value
);
    fr_state_t    state, state_nx;
    logic [W-1:0] captured;

    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) state <= FR_IDLE;
        else            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE: if (id_start) state_nx = FR_HELD;
            FR_HELD: if (frame_err || frame_ok) state_nx = FR_IDLE;
        endcase
    end

    // Outputs: capture on arm/recapture, strobe on commit
    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) begin
            captured <= '0;
            ts_valid <= 1'b0;
            ts_value <= '0;
        end else begin
            ts_valid <= 1'b0;
            unique case (state)
                FR_IDLE: if (id_start) captured <= count;
                FR_HELD: begin
                    if (frame_err) begin
                        captured <= captured;
                    end else if (frame_ok) begin
                        ts_valid <= 1'b1;
                        ts_value <= captured;
                    end else if (id_start) begin
                        captured <= count;
                    end
                end
            endcase
        end
    end

    // R7
    err_no_strobe_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        frame_err |=> !ts_valid);

    // R6
    strobe_single_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        ts_valid |=> !ts_valid);
endmodule

// File: rtl/cts_timer.sv
module cts_timer
    import cts_pkg::*;
#(
    parameter int W = CTS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         can_clk,
    input  logic         can_rst_n,
    input  logic         cpu_clk,
    input  logic         cpu_rst_n,
    input  logic         bit_tick,
    input  logic         freeze,
    input  logic         id_start,
    input  logic         frame_ok,
    input  logic         frame_err,
    input  logic         cpu_wr_en,
    input  logic [15:0]  cpu_wr_data,
    output logic [15:0]  cpu_rd_data,
    output logic         cpu_wr_pending,
    output logic [15:0]  count_out,
    output logic         ts_valid,
    output logic [15:0]  ts_value
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] count;
    logic         load_en;
    logic [W-1:0] load_val;

    cts_wr_bridge #(.W(W), .STAGES(STAGES)) u_wr (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_pending(cpu_wr_pending),
        .can_clk(can_clk), .can_rst_n(can_rst_n),
        .load_en(load_en), .load_val(load_val)
    );

    // Load beats tick; freeze only blocks ticks
    always_ff @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n)               count <= '0;
        else if (load_en)             count <= load_val;
        else if (bit_tick && !freeze) count <= count + 1'b1;
    end

    assign count_out = count;

    cts_frame_ts #(.W(W)) u_frame (
        .can_clk(can_clk), .can_rst_n(can_rst_n), .count(count),
        .id_start(id_start), .frame_ok(frame_ok), .frame_err(frame_err),
        .ts_valid(ts_valid), .ts_value(ts_value)
    );

    cts_rd_mirror #(.W(W), .STAGES(STAGES)) u_rd (
        .can_clk(can_clk), .can_rst_n(can_rst_n), .count(count),
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .rd_data(cpu_rd_data)
    );

    // R3
    wrap_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        (count == CNT_MAX && bit_tick && !freeze && !load_en) |=> (count == '0));

    // R4
    freeze_hold_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        (freeze && !load_en) |=> $stable(count));

    // R10
    load_wins_chk: assert property (@(posedge can_clk) disable iff (!can_rst_n)
        load_en |=> (count == $past(load_val)));
endmodule

// File: tb/cts_timer_tb.sv
module cts_timer_tb;
    logic can_clk, cpu_clk, can_rst_n, cpu_rst_n;
    logic bit_tick, freeze, id_start, frame_ok, frame_err, cpu_wr_en;
    logic [15:0] cpu_wr_data, cpu_rd_data, count_out, ts_value;
    logic cpu_wr_pending, ts_valid;

    int checks = 0;
    int fails = 0;
    string tag = "R2";

    // reference model state
    logic [15:0] m_cnt, m_cap, m_tsval, m_ld, wr_val;
    int  m_held, m_tsv, dn, m_pend;
    bit  wr_arm;

    cts_timer u_dut (
        .can_clk(can_clk), .can_rst_n(can_rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
        .bit_tick(bit_tick), .freeze(freeze), .id_start(id_start), .frame_ok(frame_ok),
        .frame_err(frame_err), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_data(cpu_rd_data), .cpu_wr_pending(cpu_wr_pending), .count_out(count_out),
        .ts_valid(ts_valid), .ts_value(ts_value)
    );

    initial begin
        cpu_clk = 0;
        forever #5 cpu_clk = ~cpu_clk;
    end
    initial begin
        can_clk = 0;
        #3;
        forever begin can_clk = 1; #5; can_clk = 0; #5; end
    end

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // CAN-domain reference model
    always @(posedge can_clk or negedge can_rst_n) begin
        if (!can_rst_n) begin
            m_cnt = 0; m_cap = 0; m_tsval = 0; m_held = 0; m_tsv = 0; dn = 0;
        end else begin
            m_tsv = 0;
            if (m_held == 1) begin
                if (frame_err) m_held = 0;
                else if (frame_ok) begin m_tsv = 1; m_tsval = m_cap; m_held = 0; end
                else if (id_start) m_cap = m_cnt;
            end else if (id_start) begin
                m_cap = m_cnt; m_held = 1;
            end
            if (dn == 1) m_cnt = m_ld;
            else if (bit_tick && !freeze) m_cnt = m_cnt + 16'd1;
            if (dn > 0) dn--;
            if (wr_arm) begin wr_arm = 0; dn = 2; m_ld = wr_val; end
        end
    end

    // CPU-domain reference model
    always @(posedge cpu_clk or negedge cpu_rst_n) begin
        if (!cpu_rst_n) begin
            m_pend = 0; wr_arm = 0; wr_val = 0;
        end else if (cpu_wr_en && m_pend == 0) begin
            m_pend = 5; wr_arm = 1; wr_val = cpu_wr_data;
        end else if (m_pend > 0) m_pend--;
    end

    // per-clock comparison
    always @(negedge can_clk) if (can_rst_n) begin
        chk(tag, "count_out", count_out, m_cnt);
        chk(m_tsv ? "R6" : "R7", "ts_valid", ts_valid, m_tsv);
        if (m_tsv == 1) chk("R5", "ts_value", ts_value, m_tsval);
    end
    always @(negedge cpu_clk) if (cpu_rst_n) begin
        chk("R9", "cpu_wr_pending", cpu_wr_pending, (m_pend > 0) ? 1 : 0);
    end

    task automatic can_cycles(int n);
        repeat (n) @(negedge can_clk);
    endtask

    task automatic cpu_write(logic [15:0] v);
        @(negedge cpu_clk);
        cpu_wr_en = 1; cpu_wr_data = v;
        @(negedge cpu_clk);
        cpu_wr_en = 0;
    endtask

    task automatic frame(int pre, bit ok, bit err);
        @(negedge can_clk); id_start = 1; bit_tick = 1;
        @(negedge can_clk); id_start = 0;
        can_cycles(pre);
        frame_ok = ok; frame_err = err;
        @(negedge can_clk); frame_ok = 0; frame_err = 0;
        can_cycles(2);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        can_rst_n = 0; cpu_rst_n = 0;
        bit_tick = 0; freeze = 0; id_start = 0; frame_ok = 0; frame_err = 0;
        cpu_wr_en = 0; cpu_wr_data = 0;
        #52;
        // R1 reset state
        chk("R1", "count_out", count_out, 0);
        chk("R1", "cpu_wr_pending", cpu_wr_pending, 0);
        chk("R1", "ts_valid", ts_valid, 0);
        can_rst_n = 1; cpu_rst_n = 1;

        // R2 irregular tick pattern
        tag = "R2";
        for (int i = 0; i < 60; i++) begin
            @(negedge can_clk); bit_tick = ($urandom % 3) != 0;
        end
        // R4 freeze with ticks
        tag = "R4";
        freeze = 1; bit_tick = 1;
        can_cycles(12);
        freeze = 0;

        // R8 / R10 write with ticks running, then R3 wrap
        tag = "R10";
        bit_tick = 1;
        cpu_write(16'hFFF0);
        repeat (8) @(negedge cpu_clk);
        tag = "R3";
        can_cycles(25);

        // R9 second write while first is pending is ignored
        tag = "R9";
        cpu_write(16'h1234);
        cpu_write(16'hBEEF);
        repeat (8) @(negedge cpu_clk);
        chk("R9", "pending low after ack", cpu_wr_pending, 0);

        // R11 write under freeze
        tag = "R11";
        freeze = 1;
        cpu_write(16'h8000);
        repeat (8) @(negedge cpu_clk);
        @(negedge can_clk);
        chk("R11", "loaded under freeze", count_out, 16'h8000);
        freeze = 0;

        // R8 write with ticks off: exact value
        tag = "R8";
        bit_tick = 0;
        cpu_write(16'h0042);
        repeat (8) @(negedge cpu_clk);
        @(negedge can_clk);
        chk("R8", "written value", count_out, 16'h0042);

        // R5/R6 good frames, R7 error frames
        tag = "R5";
        frame(7, 1, 0);
        frame(3, 1, 0);
        @(negedge can_clk); frame_ok = 1;   // no open frame: R6
        @(negedge can_clk); frame_ok = 0;
        tag = "R7";
        frame(5, 0, 1);
        @(negedge can_clk); frame_ok = 1;   // after error, no strobe
        @(negedge can_clk); frame_ok = 0;
        frame(4, 1, 1);                     // both together: error wins
        // R5 recapture
        tag = "R5";
        @(negedge can_clk); id_start = 1;
        can_cycles(3);
        id_start = 0;
        frame(2, 1, 0);

        // R12 read path
        tag = "R12";
        freeze = 1; bit_tick = 0;
        repeat (30) @(negedge cpu_clk);
        chk("R12", "cpu_rd_data", cpu_rd_data, count_out);
        freeze = 0;

        can_cycles(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule